// File: doc/BRIEF.md
# SMBus memory command decoder

This block sits above a bit-level SMBus slave and turns its byte events into memory operations. The slave reports a start (first start or repeated start), a stop, and each received byte together with a flag that marks the first byte after a start. For every received byte the decoder answers one cycle later with an ACK or NACK decision. It then drives pointer updates, single-byte writes, page erase requests and block-write data toward a memory controller.

The command byte picks the meaning of a transaction by its value range. Values up to `RAM_TOP` set a RAM pointer in a send-byte transaction. Values from `EE_HI_MIN` to `EE_HI_MAX` are the upper part of an EEPROM address, and the next byte completes it. `BLK_CMD` opens a block write at the pointer most recently set. A three-bit control input sets what happens after an EEPROM address is complete: bit 2 turns the next byte into a page erase, bit 1 turns it into a data write, and bit 0 lets a repeated start lead straight into a read. While the memory controller reports an erase in progress, every byte gets a NACK.

The state machine has these states: `S_IDLE` (no transaction), `S_ADDR` (waiting for the address byte), `S_CMD` (waiting for the command), `S_EE_LO` (waiting for the low address byte), `S_EE_DATA` (address complete; waiting for an erase, write or repeated start), `S_BLK_CNT` (waiting for the byte count), `S_BLK_DATA` (streaming data), `S_BLK_TAIL` (waiting for the trailing check byte), `S_BLK_END` (block complete), `S_DONE` (transaction complete; further bytes get a NACK) and `S_IGNORE` (rejected; all bytes get a NACK). A stop goes to `S_IDLE` from any state. A start goes to `S_ADDR` from any state. A received byte moves the machine as R2 to R9 describe.

Top module: `smb_mem_cmd_dec`

## Requirements
- R1: After reset, `ack_vld`, `wr_req`, `erase_req`, `blk_vld`, `blk_done` and `rd_go` are 0, and `ram_ptr`, `ee_ptr` and `ptr_is_ee` are 0.
- R2: Each received byte gets exactly one `ack_vld` pulse in the next cycle, with `ack`=1 for ACK and 0 for NACK. An address byte is accepted only if it carries the first-byte flag and its bits [7:1] equal `SLAVE_ADDR`. If the direction bit [0] is 1, the byte is ACKed and the decoder moves to `S_DONE`. Any other address byte is NACKed, and every later byte of that transaction is NACKed with no effect.
- R3: A command byte at or below `RAM_TOP` is ACKed, loads `ram_ptr`, clears `ptr_is_ee`, and ends decoding. Further bytes are NACKed.
- R4: A command byte between `RAM_TOP` and `EE_HI_MIN`, or above `EE_HI_MAX` and not equal to `BLK_CMD`, is NACKed and changes no pointer.
- R5: A command from `EE_HI_MIN` to `EE_HI_MAX` is ACKed, and so is the byte after it. `ee_ptr` then becomes {command[EE_AW-9:0], byte} and `ptr_is_ee` becomes 1.
- R6: With control bit 2 clear and bit 1 set, the byte after a complete EEPROM address is ACKed. It gives a one-cycle `wr_req` with `wr_addr`=`ee_ptr` and `wr_data`= that byte.
- R7: With control bit 2 set, that byte is ACKed. It gives a one-cycle `erase_req` with `erase_page`=`ee_ptr` bits above the in-page offset, and no `wr_req`. With bits 2 and 1 both clear, the byte is NACKed.
- R8: With control bit 0 set, a start arriving in `S_EE_DATA` with no erase busy gives a one-cycle `rd_go`. With bit 0 clear, no `rd_go` is given.
- R9: `BLK_CMD` is NACKed if `ptr_is_ee`=1 and control bit 1 is clear; otherwise it is ACKed. A count byte equal to `BLK_LEN` is ACKed and any other value is NACKed. The next `BLK_LEN` bytes are ACKed, each with a `blk_vld` pulse carrying the byte on `blk_data`. One trailing byte is then ACKed without `blk_vld`, and later bytes are NACKed.
- R10: While `erase_busy` is 1, every received byte is NACKed, no `wr_req` or `erase_req` is issued, and the transaction is ignored.
- R11: A stop or a start arriving mid-transaction drops any partial request. An EEPROM command without its low byte leaves `ee_ptr` unchanged. `blk_done` pulses at a stop only after the trailing byte of a block has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| ev_byte | input | 1 | Byte received (one-cycle pulse) |
| byte_first | input | 1 | Received byte is the first after a start |
| byte_data | input | 8 | Received byte value |
| ctl_mode | input | 3 | Control bits: [2] erase, [1] write, [0] read after address |
| erase_busy | input | 1 | Memory controller is erasing a page |
| ack_vld | output | 1 | Decision for the last byte is valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| ram_ptr | output | RAM_AW | RAM address pointer |
| ee_ptr | output | EE_AW | EEPROM address pointer |
| ptr_is_ee | output | 1 | Last pointer set was the EEPROM pointer |
| wr_req | output | 1 | Single-byte EEPROM write request |
| wr_addr | output | EE_AW | Write address |
| wr_data | output | 8 | Write data |
| erase_req | output | 1 | Page erase request |
| erase_page | output | EE_AW-log2(PAGE_BYTES) | Page to erase |
| blk_vld | output | 1 | Block data byte valid |
| blk_data | output | 8 | Block data byte |
| blk_done | output | 1 | Complete block closed by a stop |
| rd_go | output | 1 | Repeated start begins a read at `ee_ptr` |

## Verification
The bench builds the decoder with `SLAVE_ADDR` = 2Ch and `BLK_LEN` = 4; all other parameters keep their defaults. A four-byte block makes several cases short: the mismatched count, the trailing byte after the last data byte, the NACK of an extra byte, and a block cut off by an early stop. The default address and page widths keep the EEPROM upper-byte range 80h to 9Fh and the 64-byte page split, so the expected pointer and page values follow the byte values directly.

// File: rtl/smbd_pkg.sv
package smbd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_EE_LO,
        S_EE_DATA,
        S_BLK_CNT,
        S_BLK_DATA,
        S_BLK_TAIL,
        S_BLK_END,
        S_DONE,
        S_IGNORE
    } state_t;

    typedef enum logic [1:0] {
        CMD_RAM,
        CMD_EE,
        CMD_BLK,
        CMD_BAD
    } cmd_t;

endpackage

// File: rtl/smbd_cmd_class.sv
module smbd_cmd_class
    import smbd_pkg::*;
#(
    parameter logic [7:0] RAM_TOP   = 8'h6F,
    parameter logic [7:0] EE_HI_MIN = 8'h80,
    parameter logic [7:0] EE_HI_MAX = 8'h9F,
    parameter logic [7:0] BLK_CMD   = 8'hA0
) (
    input  logic [7:0] cmd,
    output cmd_t       kind
);

    always_comb begin
        if (cmd <= RAM_TOP) begin
            kind = CMD_RAM;
        end else if (cmd >= EE_HI_MIN && cmd <= EE_HI_MAX) begin
            kind = CMD_EE;
        end else if (cmd == BLK_CMD) begin
            kind = CMD_BLK;
        end else begin
            kind = CMD_BAD;
        end
    end

endmodule

// File: rtl/smbd_ptr_regs.sv
module smbd_ptr_regs #(
    parameter int RAM_AW = 7,
    parameter int EE_AW  = 13,
    localparam int HI_W  = EE_AW - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_ram,
    input  logic [RAM_AW-1:0] ram_val,
    input  logic              ld_hi,
    input  logic [HI_W-1:0]   hi_val,
    input  logic              ld_lo,
    input  logic [7:0]        lo_val,
    output logic [RAM_AW-1:0] ram_ptr,
    output logic [EE_AW-1:0]  ee_ptr,
    output logic              sel_ee
);

    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            ram_ptr <= '0;
            ee_ptr  <= '0;
            sel_ee  <= 1'b0;
        end else begin
            if (ld_hi) begin
                hi_q <= hi_val;
            end
            if (ld_lo) begin
                ee_ptr <= {hi_q, lo_val};
                sel_ee <= 1'b1;
            end else if (ld_ram) begin
                ram_ptr <= ram_val;
                sel_ee  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/smb_mem_cmd_dec.sv
module smb_mem_cmd_dec
    import smbd_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h2C,
    parameter int         BLK_LEN    = 32,
    parameter int         RAM_AW     = 7,
    parameter int         EE_AW      = 13,
    parameter int         PAGE_BYTES = 64,
    parameter logic [7:0] RAM_TOP    = 8'h6F,
    parameter logic [7:0] EE_HI_MIN  = 8'h80,
    parameter logic [7:0] EE_HI_MAX  = 8'h9F,
    parameter logic [7:0] BLK_CMD    = 8'hA0,
    localparam int        PG_OFS     = $clog2(PAGE_BYTES),
    localparam int        PAGE_W     = EE_AW - PG_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic              byte_first,
    input  logic [7:0]        byte_data,
    input  logic [2:0]        ctl_mode,
    input  logic              erase_busy,
    output logic              ack_vld,
    output logic              ack,
    output logic [RAM_AW-1:0] ram_ptr,
    output logic [EE_AW-1:0]  ee_ptr,
    output logic              ptr_is_ee,
    output logic              wr_req,
    output logic [EE_AW-1:0]  wr_addr,
    output logic [7:0]        wr_data,
    output logic              erase_req,
    output logic [PAGE_W-1:0] erase_page,
    output logic              blk_vld,
    output logic [7:0]        blk_data,
    output logic              blk_done,
    output logic              rd_go
);

    localparam int CNT_W = $clog2(BLK_LEN + 1);
    localparam int HI_W  = EE_AW - 8;

    state_t             st, st_nx;
    cmd_t               cmd_kind;
    logic [CNT_W-1:0]   cnt;
    logic               a_vld, a_ok;
    logic               do_ram, do_hi, do_lo, do_wr, do_er, do_bv, do_done, do_rd;
    logic               cnt_clr, cnt_inc;

    smbd_cmd_class #(
        .RAM_TOP   (RAM_TOP),
        .EE_HI_MIN (EE_HI_MIN),
        .EE_HI_MAX (EE_HI_MAX),
        .BLK_CMD   (BLK_CMD)
    ) u_class (
        .cmd  (byte_data),
        .kind (cmd_kind)
    );

    smbd_ptr_regs #(
        .RAM_AW (RAM_AW),
        .EE_AW  (EE_AW)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_ram  (do_ram),
        .ram_val (byte_data[RAM_AW-1:0]),
        .ld_hi   (do_hi),
        .hi_val  (byte_data[HI_W-1:0]),
        .ld_lo   (do_lo),
        .lo_val  (byte_data),
        .ram_ptr (ram_ptr),
        .ee_ptr  (ee_ptr),
        .sel_ee  (ptr_is_ee)
    );

    // Next-state and action decode
    always_comb begin
        st_nx   = st;
        a_vld   = 1'b0;
        a_ok    = 1'b0;
        do_ram  = 1'b0;
        do_hi   = 1'b0;
        do_lo   = 1'b0;
        do_wr   = 1'b0;
        do_er   = 1'b0;
        do_bv   = 1'b0;
        do_done = 1'b0;
        do_rd   = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (ev_stop) begin
            st_nx   = S_IDLE;
            do_done = (st == S_BLK_END);
        end else if (ev_start) begin
            st_nx = S_ADDR;
            do_rd = (st == S_EE_DATA) && ctl_mode[0] && !erase_busy;
        end else if (ev_byte) begin
            a_vld = 1'b1;
            if (erase_busy) begin
                st_nx = S_IGNORE;
            end else begin
                unique case (st)
                    S_ADDR: begin
                        if (byte_first && byte_data[7:1] == SLAVE_ADDR) begin
                            a_ok  = 1'b1;
                            st_nx = byte_data[0] ? S_DONE : S_CMD;
                        end else begin
                            st_nx = S_IGNORE;
                        end
                    end
                    S_CMD: begin
                        unique case (cmd_kind)
                            CMD_RAM: begin
                                a_ok   = 1'b1;
                                do_ram = 1'b1;
                                st_nx  = S_DONE;
                            end
                            CMD_EE: begin
                                a_ok  = 1'b1;
                                do_hi = 1'b1;
                                st_nx = S_EE_LO;
                            end
                            CMD_BLK: begin
                                if (ptr_is_ee && !ctl_mode[1]) begin
                                    st_nx = S_IGNORE;
                                end else begin
                                    a_ok    = 1'b1;
                                    cnt_clr = 1'b1;
                                    st_nx   = S_BLK_CNT;
                                end
                            end
                            default: st_nx = S_IGNORE;
                        endcase
                    end
                    S_EE_LO: begin
                        a_ok  = 1'b1;
                        do_lo = 1'b1;
                        st_nx = S_EE_DATA;
                    end
                    S_EE_DATA: begin
                        if (ctl_mode[2]) begin
                            a_ok  = 1'b1;
                            do_er = 1'b1;
                            st_nx = S_DONE;
                        end else if (ctl_mode[1]) begin
                            a_ok  = 1'b1;
                            do_wr = 1'b1;
                            st_nx = S_DONE;
                        end else begin
                            st_nx = S_IGNORE;
                        end
                    end
                    S_BLK_CNT: begin
                        if (byte_data == 8'(BLK_LEN)) begin
                            a_ok  = 1'b1;
                            st_nx = S_BLK_DATA;
                        end else begin
                            st_nx = S_IGNORE;
                        end
                    end
                    S_BLK_DATA: begin
                        a_ok    = 1'b1;
                        do_bv   = 1'b1;
                        cnt_inc = 1'b1;
                        if (cnt == CNT_W'(BLK_LEN - 1)) begin
                            st_nx = S_BLK_TAIL;
                        end
                    end
                    S_BLK_TAIL: begin
                        a_ok  = 1'b1;
                        st_nx = S_BLK_END;
                    end
                    default: st_nx = st;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Block byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_clr) begin
            cnt <= '0;
        end else if (cnt_inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld    <= 1'b0;
            ack        <= 1'b0;
            wr_req     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            erase_req  <= 1'b0;
            erase_page <= '0;
            blk_vld    <= 1'b0;
            blk_data   <= '0;
            blk_done   <= 1'b0;
            rd_go      <= 1'b0;
        end else begin
            ack_vld   <= a_vld;
            ack       <= a_ok;
            wr_req    <= do_wr;
            erase_req <= do_er;
            blk_vld   <= do_bv;
            blk_done  <= do_done;
            rd_go     <= do_rd;
            if (do_wr) begin
                wr_addr <= ee_ptr;
                wr_data <= byte_data;
            end
            if (do_er) begin
                erase_page <= ee_ptr[EE_AW-1:PG_OFS];
            end
            if (do_bv) begin
                blk_data <= byte_data;
            end
        end
    end

endmodule

// File: rtl/smbd_checker.sv
module smbd_checker #(
    parameter int         RAM_AW  = 7,
    parameter int         EE_AW   = 13,
    parameter logic [7:0] RAM_TOP = 8'h6F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              ev_byte,
    input logic              erase_busy,
    input logic              ack_vld,
    input logic              ack,
    input logic              wr_req,
    input logic              erase_req,
    input logic [RAM_AW-1:0] ram_ptr,
    input logic [EE_AW-1:0]  ee_ptr
);

    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte && !ev_start && !ev_stop) |=> ack_vld); // R2

    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_byte |=> !ack_vld); // R2

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte && erase_busy && !ev_start && !ev_stop) |=> (ack_vld && !ack)); // R10

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |=> !(wr_req || erase_req)); // R10

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && erase_req)); // R7

    AST_WR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (ack_vld && ack)); // R6

    AST_STOP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_byte) |=> $stable(ee_ptr)); // R11

    AST_RAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        8'(ram_ptr) <= RAM_TOP); // R3

endmodule

bind smb_mem_cmd_dec smbd_checker #(
    .RAM_AW  (RAM_AW),
    .EE_AW   (EE_AW),
    .RAM_TOP (RAM_TOP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_byte    (ev_byte),
    .erase_busy (erase_busy),
    .ack_vld    (ack_vld),
    .ack        (ack),
    .wr_req     (wr_req),
    .erase_req  (erase_req),
    .ram_ptr    (ram_ptr),
    .ee_ptr     (ee_ptr)
);

// File: tb/tb_smb_mem_cmd_dec.sv
`timescale 1ns/1ps
module tb_smb_mem_cmd_dec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0, byte_first = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [2:0]  ctl_mode = '0;
    logic        erase_busy = 1'b0;
    logic        ack_vld, ack, ptr_is_ee, wr_req, erase_req, blk_vld, blk_done, rd_go;
    logic [6:0]  ram_ptr;
    logic [12:0] ee_ptr, wr_addr;
    logic [7:0]  wr_data, blk_data;
    logic [6:0]  erase_page;

    int checks = 0;
    int errors = 0;

    // snapshot of outputs one cycle after an event
    logic s_av, s_ack, s_wr, s_er, s_bv, s_done, s_rd;
    logic [7:0] s_bd;

    always #2 clk = ~clk;

    smb_mem_cmd_dec #(.SLAVE_ADDR(7'h2C), .BLK_LEN(4)) dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .byte_first(byte_first), .byte_data(byte_data),
        .ctl_mode(ctl_mode), .erase_busy(erase_busy),
        .ack_vld(ack_vld), .ack(ack), .ram_ptr(ram_ptr), .ee_ptr(ee_ptr),
        .ptr_is_ee(ptr_is_ee), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_req(erase_req), .erase_page(erase_page), .blk_vld(blk_vld),
        .blk_data(blk_data), .blk_done(blk_done), .rd_go(rd_go)
    );

    // kind: 0 start, 1 stop, 2 byte; {kind[11:10], first[9], exp_ack[8], data[7:0]}
    localparam int NV = 29;
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 8'h00},   // R2/R3: RAM pointer 10h
        {2'd2, 1'b1, 1'b1, 8'h58},
        {2'd2, 1'b0, 1'b1, 8'h10},
        {2'd2, 1'b0, 1'b0, 8'h55},
        {2'd1, 1'b0, 1'b0, 8'h00},
        {2'd0, 1'b0, 1'b0, 8'h00},   // R2: other slave
        {2'd2, 1'b1, 1'b0, 8'h5A},
        {2'd2, 1'b0, 1'b0, 8'h10},
        {2'd1, 1'b0, 1'b0, 8'h00},
        {2'd0, 1'b0, 1'b0, 8'h00},   // R4: gap command
        {2'd2, 1'b1, 1'b1, 8'h58},
        {2'd2, 1'b0, 1'b0, 8'h70},
        {2'd1, 1'b0, 1'b0, 8'h00},
        {2'd0, 1'b0, 1'b0, 8'h00},   // R4: command above block code
        {2'd2, 1'b1, 1'b1, 8'h58},
        {2'd2, 1'b0, 1'b0, 8'hA1},
        {2'd1, 1'b0, 1'b0, 8'h00},
        {2'd0, 1'b0, 1'b0, 8'h00},   // R5/R7: address 0540h, no mode -> NACK
        {2'd2, 1'b1, 1'b1, 8'h58},
        {2'd2, 1'b0, 1'b1, 8'h85},
        {2'd2, 1'b0, 1'b1, 8'h40},
        {2'd2, 1'b0, 1'b0, 8'h12},
        {2'd1, 1'b0, 1'b0, 8'h00},
        {2'd0, 1'b0, 1'b0, 8'h00},   // R2: read direction
        {2'd2, 1'b1, 1'b1, 8'h59},
        {2'd1, 1'b0, 1'b0, 8'h00},
        {2'd0, 1'b0, 1'b0, 8'h00},   // R2: address without first flag
        {2'd2, 1'b0, 1'b0, 8'h58},
        {2'd1, 1'b0, 1'b0, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic step(input int kind, input logic [7:0] d, input logic f);
        @(negedge clk);
        ev_start   = (kind == 0);
        ev_stop    = (kind == 1);
        ev_byte    = (kind == 2);
        byte_first = f;
        byte_data  = d;
        @(negedge clk);
        ev_start = 1'b0; ev_stop = 1'b0; ev_byte = 1'b0; byte_first = 1'b0;
        s_av = ack_vld; s_ack = ack; s_wr = wr_req; s_er = erase_req;
        s_bv = blk_vld; s_bd = blk_data; s_done = blk_done; s_rd = rd_go;
    endtask

    task automatic bx(input logic [7:0] d, input logic f, input logic exp_ack, input string tag);
        step(2, d, f);
        chk(tag, {s_av, s_ack}, {1'b1, exp_ack});
    endtask

    task automatic hdr(input logic [7:0] cmd, input logic exp_ack, input string tag);
        step(0, 8'h00, 1'b0);
        bx(8'h58, 1'b1, 1'b1, tag);
        bx(cmd, 1'b0, exp_ack, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 strobes", {ack_vld, wr_req, erase_req, blk_vld, blk_done, rd_go}, 0);
        chk("R1 pointers", {ram_ptr, ee_ptr, ptr_is_ee}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            v = VEC[i];
            step(int'(v[11:10]), v[7:0], v[9]);
            if (v[11:10] == 2'd2) begin
                chk($sformatf("R2 vector %0d ack", i), {s_av, s_ack}, {1'b1, v[8]});
            end
        end
        chk("R3 ram_ptr loaded, R4 untouched", ram_ptr, 7'h10);
        chk("R5 ee_ptr", ee_ptr, 13'h0540);
        chk("R5 ptr_is_ee", ptr_is_ee, 1);

        // R6 single-byte write
        ctl_mode = 3'b010;
        hdr(8'h9F, 1'b1, "R6 hi");
        bx(8'hC3, 1'b0, 1'b1, "R6 lo");
        bx(8'h5A, 1'b0, 1'b1, "R6 data ack");
        chk("R6 wr_req", {s_wr, s_er}, 2'b10);
        chk("R6 wr_addr", wr_addr, 13'h1FC3);
        chk("R6 wr_data", wr_data, 8'h5A);
        step(1, 0, 0);

        // R7 page erase takes priority over write
        ctl_mode = 3'b110;
        hdr(8'h81, 1'b1, "R7 hi");
        bx(8'h7F, 1'b0, 1'b1, "R7 lo");
        bx(8'hA5, 1'b0, 1'b1, "R7 data ack");
        chk("R7 erase_req only", {s_wr, s_er}, 2'b01);
        chk("R7 erase_page", erase_page, 7'd5);
        step(1, 0, 0);

        // R11 partial address dropped by stop and by start
        ctl_mode = 3'b000;
        hdr(8'h88, 1'b1, "R11 hi");
        step(1, 0, 0);
        chk("R11 ptr after stop", ee_ptr, 13'h017F);
        hdr(8'h88, 1'b1, "R11 hi2");
        step(0, 0, 0);
        bx(8'h58, 1'b1, 1'b1, "R11 addr after restart");
        step(1, 0, 0);
        chk("R11 ptr after restart", ee_ptr, 13'h017F);

        // R8 read after address
        ctl_mode = 3'b001;
        hdr(8'h80, 1'b1, "R8 hi");
        bx(8'h20, 1'b0, 1'b1, "R8 lo");
        step(0, 0, 0);
        chk("R8 rd_go set", s_rd, 1);
        step(1, 0, 0);
        ctl_mode = 3'b000;
        hdr(8'h80, 1'b1, "R8 hi2");
        bx(8'h20, 1'b0, 1'b1, "R8 lo2");
        step(0, 0, 0);
        chk("R8 rd_go clear mode", s_rd, 0);
        step(1, 0, 0);

        // R10 erase busy
        erase_busy = 1'b1;
        step(0, 0, 0);
        bx(8'h58, 1'b1, 1'b0, "R10 addr nack");
        bx(8'h10, 1'b0, 1'b0, "R10 later nack");
        step(1, 0, 0);
        erase_busy = 1'b0;
        ctl_mode = 3'b010;
        hdr(8'h90, 1'b1, "R10 hi");
        bx(8'h01, 1'b0, 1'b1, "R10 lo");
        erase_busy = 1'b1;
        bx(8'h33, 1'b0, 1'b0, "R10 data nack");
        chk("R10 no write", {s_wr, s_er}, 0);
        erase_busy = 1'b0;
        step(1, 0, 0);
        chk("R3 ram_ptr untouched by busy", ram_ptr, 7'h10);

        // R9 block write
        ctl_mode = 3'b000;
        hdr(8'hA0, 1'b0, "R9 EE target no write mode");
        step(1, 0, 0);
        ctl_mode = 3'b010;
        hdr(8'hA0, 1'b1, "R9 cmd ack");
        bx(8'h05, 1'b0, 1'b0, "R9 bad count");
        step(1, 0, 0);
        hdr(8'hA0, 1'b1, "R9 cmd ack2");
        bx(8'h04, 1'b0, 1'b1, "R9 count");
        for (int k = 0; k < 4; k++) begin
            bx(8'hD0 + 8'(k), 1'b0, 1'b1, "R9 data ack");
            chk("R9 blk_vld data", {s_bv, s_bd}, {1'b1, 8'hD0 + 8'(k)});
        end
        bx(8'hEE, 1'b0, 1'b1, "R9 tail ack");
        chk("R9 tail no blk_vld", s_bv, 0);
        bx(8'h11, 1'b0, 1'b0, "R9 extra nack");
        step(1, 0, 0);
        chk("R11 blk_done complete", s_done, 1);
        hdr(8'hA0, 1'b1, "R11 cmd");
        bx(8'h04, 1'b0, 1'b1, "R11 count");
        bx(8'hD0, 1'b0, 1'b1, "R11 data");
        step(1, 0, 0);
        chk("R11 no blk_done partial", s_done, 0);
        ctl_mode = 3'b000;
        hdr(8'h20, 1'b1, "R3 ram ptr");
        step(1, 0, 0);
        chk("R3 ptr_is_ee cleared", ptr_is_ee, 0);
        hdr(8'hA0, 1'b1, "R9 RAM target");
        step(1, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule